// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block decides whether the power bridge of a two-phase motor driver may drive its outputs. It gathers the standby and enable controls and the digital results of four protection comparators: overcurrent, over-temperature with a separate recovery flag, and undervoltage on both the logic and the motor supply. From these it makes one registered output-enable and reports the state of each fault. The step sequencer beside it keeps running through any fault. Only the bridge gate is removed, exactly as when enable is low.

Each fault recovers in its own way. An overcurrent detect is accepted only after it has been present for a blanking window counted in clock cycles. Once accepted, it stays latched. The latch is released only by an enable rise that follows a long enough low period, or by an undervoltage event. Thermal and undervoltage faults clear by themselves when their comparators report recovery. Standby overrides everything. All inputs are taken to be synchronous to `clk`.

Top module: `drv_fault_supervisor`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `out_en_o`, `fault_live_o`, `fault_seen_o` and `fault_any_o` are all zero.
- R2: With standby high, enable high and no fault, `out_en_o` is 1 one clock edge after those conditions are sampled. Enable low gives `out_en_o` 0 on the next edge.
- R3: `standby_n_i` low forces `out_en_o` to 0 on the next edge, whatever the other inputs are. It changes no fault flag.
- R4: An overcurrent is accepted only when `ocp_raw_i` is sampled high on `MASK_CYC` consecutive edges. A burst of fewer edges leaves no trace. On acceptance, bit 0 of `fault_live_o` and `fault_any_o` rise and `out_en_o` falls, all on the same edge.
- R5: An accepted overcurrent stays latched after `ocp_raw_i` falls, and `out_en_o` stays 0.
- R6: The overcurrent latch clears on the edge where enable is first sampled high after at least `MIN_LOW_CYC` consecutive low samples. A shorter low period does not clear it.
- R7: Either undervoltage input high clears the overcurrent latch and sets bit 2 of `fault_live_o` on the next edge, and `out_en_o` is 0. One edge after both inputs are low, bit 2 is clear and `out_en_o` returns.
- R8: `temp_hot_i` high sets the thermal fault (bit 1 of `fault_live_o`) on the next edge. The fault holds until `temp_cool_i` is sampled high with `temp_hot_i` low. While it holds, `out_en_o` is 0.
- R9: `fault_any_o` is the OR of the live bits. `fault_seen_o` uses the same bit positions (0 overcurrent, 1 thermal, 2 undervoltage). Each of its bits is set when the cause occurs and stays set until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_n_i | input | 1 | Low puts the bridge off with top priority |
| enable_i | input | 1 | Output enable request; a qualified rise clears the overcurrent latch |
| ocp_raw_i | input | 1 | Raw overcurrent comparator result |
| temp_hot_i | input | 1 | Over-temperature trip comparator |
| temp_cool_i | input | 1 | Temperature is below the recovery point |
| uv_logic_i | input | 1 | Logic supply undervoltage |
| uv_motor_i | input | 1 | Motor supply undervoltage |
| out_en_o | output | 1 | Bridge output enable, registered |
| fault_live_o | output | 3 | Current fault state: bit0 overcurrent, bit1 thermal, bit2 undervoltage |
| fault_seen_o | output | 3 | Sticky record of the same causes |
| fault_any_o | output | 1 | Any live fault |

## Verification
The assertions assume that every input is already synchronous to `clk` and is held stable around the rising edge. They also assume that `rst` is high from time zero for at least one edge, because the sticky-bit and overcurrent-rise properties look back one cycle. The bench changes inputs only on falling edges and asserts reset before the first rising edge. It drives the two temperature flags as a real comparator pair would and never holds both high at once. The bench uses short blanking and enable-low windows so that every edge of each window can be reached.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    typedef struct packed {
        logic uv;
        logic therm;
        logic ocp;
    } fault_t;

    typedef enum logic {
        TH_NORMAL = 1'b0,
        TH_HOT    = 1'b1
    } therm_e;

    function automatic int cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/dfs_ocp_filter.sv
module dfs_ocp_filter #(
    parameter int MASK_CYC = 800
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    input  logic clr_i,
    output logic latch_o,
    output logic latch_next_o
);
    localparam int W = dfs_pkg::cnt_w(MASK_CYC);
    localparam logic [W-1:0] LIM = W'(MASK_CYC - 1);

    logic [W-1:0] cnt_q, cnt_d;
    logic         at_lim;
    logic         accept;

    always_comb begin
        at_lim = (cnt_q == LIM);
        accept = raw_i && at_lim;
        if (clr_i || !raw_i)
            cnt_d = '0;
        else if (at_lim)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + W'(1);
        if (clr_i)
            latch_next_o = 1'b0;
        else if (accept)
            latch_next_o = 1'b1;
        else
            latch_next_o = latch_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            latch_o <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            latch_o <= latch_next_o;
        end
    end

    AST_OCP_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt_q <= LIM); // R4
    AST_OCP_MASKED: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_o) |-> ($past(raw_i) && $past(cnt_q) == LIM)); // R4
    AST_OCP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (latch_o && !clr_i) |=> latch_o); // R5
    AST_OCP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !latch_o); // R6

endmodule

// File: rtl/dfs_en_qual.sv
module dfs_en_qual #(
    parameter int MIN_LOW_CYC = 30000
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic rise_ok_o
);
    localparam int W = dfs_pkg::cnt_w(MIN_LOW_CYC);
    localparam logic [W-1:0] SAT = W'(MIN_LOW_CYC);

    logic [W-1:0] low_q, low_d;

    always_comb begin
        rise_ok_o = en_i && (low_q == SAT);
        if (en_i)
            low_d = '0;
        else if (low_q == SAT)
            low_d = low_q;
        else
            low_d = low_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            low_q <= '0;
        else
            low_q <= low_d;
    end

    AST_EN_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) low_q <= SAT); // R6
    AST_EN_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        rise_ok_o |-> !$past(en_i)); // R6

endmodule

// File: rtl/dfs_thermal.sv
module dfs_thermal (
    input  logic clk,
    input  logic rst,
    input  logic hot_i,
    input  logic cool_i,
    output logic hot_o,
    output logic hot_next_o
);
    import dfs_pkg::*;

    therm_e st_q, st_d;

    always_comb begin
        if (hot_i)
            st_d = TH_HOT;
        else if (st_q == TH_HOT && cool_i)
            st_d = TH_NORMAL;
        else
            st_d = st_q;
        hot_next_o = (st_d == TH_HOT);
        hot_o      = (st_q == TH_HOT);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= TH_NORMAL;
        else
            st_q <= st_d;
    end

    AST_THERM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q == TH_HOT && !cool_i) |=> st_q == TH_HOT); // R8
    AST_THERM_TRIP: assert property (@(posedge clk) disable iff (rst)
        hot_i |=> st_q == TH_HOT); // R8

endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor #(
    parameter int MASK_CYC    = 800,
    parameter int MIN_LOW_CYC = 30000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       standby_n_i,
    input  logic       enable_i,
    input  logic       ocp_raw_i,
    input  logic       temp_hot_i,
    input  logic       temp_cool_i,
    input  logic       uv_logic_i,
    input  logic       uv_motor_i,
    output logic       out_en_o,
    output logic [2:0] fault_live_o,
    output logic [2:0] fault_seen_o,
    output logic       fault_any_o
);
    import dfs_pkg::*;

    logic   uv_any;
    logic   rise_ok;
    logic   ocp_clr;
    logic   ocp_q, ocp_next;
    logic   hot_q, hot_next;
    logic   uv_q;
    fault_t live_next, live_q, seen_q;
    logic   out_en_d;

    assign uv_any  = uv_logic_i | uv_motor_i;
    assign ocp_clr = rise_ok | uv_any;

    dfs_en_qual #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_enq (
        .clk       (clk),
        .rst       (rst),
        .en_i      (enable_i),
        .rise_ok_o (rise_ok)
    );

    dfs_ocp_filter #(.MASK_CYC(MASK_CYC)) u_ocp (
        .clk          (clk),
        .rst          (rst),
        .raw_i        (ocp_raw_i),
        .clr_i        (ocp_clr),
        .latch_o      (ocp_q),
        .latch_next_o (ocp_next)
    );

    dfs_thermal u_thm (
        .clk        (clk),
        .rst        (rst),
        .hot_i      (temp_hot_i),
        .cool_i     (temp_cool_i),
        .hot_o      (hot_q),
        .hot_next_o (hot_next)
    );

    always_comb begin
        live_next.ocp   = ocp_next;
        live_next.therm = hot_next;
        live_next.uv    = uv_any;
        out_en_d = standby_n_i && enable_i && (live_next == '0);
        live_q.ocp   = ocp_q;
        live_q.therm = hot_q;
        live_q.uv    = uv_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            uv_q        <= 1'b0;
            seen_q      <= '0;
            out_en_o    <= 1'b0;
            fault_any_o <= 1'b0;
        end else begin
            uv_q        <= uv_any;
            seen_q      <= seen_q | live_next;
            out_en_o    <= out_en_d;
            fault_any_o <= |live_next;
        end
    end

    assign fault_live_o = live_q;
    assign fault_seen_o = seen_q;

    AST_STBY_PRIO: assert property (@(posedge clk) disable iff (rst)
        !standby_n_i |=> !out_en_o); // R3
    AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> !out_en_o); // R2
    AST_UV_OFF: assert property (@(posedge clk) disable iff (rst)
        uv_any |=> (!out_en_o && !fault_live_o[0] && fault_live_o[2])); // R7
    AST_FAULT_GATES: assert property (@(posedge clk) disable iff (rst)
        fault_any_o |-> !out_en_o); // R9
    AST_ANY_MATCH: assert property (@(posedge clk) disable iff (rst)
        fault_any_o == (|fault_live_o)); // R9
    AST_SEEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fault_seen_o & $past(fault_seen_o)) == $past(fault_seen_o)); // R9

endmodule

// File: tb/tb_drv_fault_supervisor.sv
module tb_drv_fault_supervisor;
    localparam int MASK = 8;
    localparam int MINL = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       standby_n = 1'b1, enable = 1'b0, ocp = 1'b0;
    logic       hot = 1'b0, cool = 1'b1, uvl = 1'b0, uvm = 1'b0;
    logic       out_en, any;
    logic [2:0] live, seen;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    drv_fault_supervisor #(.MASK_CYC(MASK), .MIN_LOW_CYC(MINL)) dut (
        .clk(clk), .rst(rst), .standby_n_i(standby_n), .enable_i(enable),
        .ocp_raw_i(ocp), .temp_hot_i(hot), .temp_cool_i(cool),
        .uv_logic_i(uvl), .uv_motor_i(uvm), .out_en_o(out_en),
        .fault_live_o(live), .fault_seen_o(seen), .fault_any_o(any)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        step(3);
        rst = 1'b0;
        step(1);
        check("R1 out_en", {3'b0, out_en}, 4'h0);
        check("R1 live", {1'b0, live}, 4'h0);
        check("R1 seen", {1'b0, seen}, 4'h0);
        check("R1 any", {3'b0, any}, 4'h0);
    endtask

    task automatic t_enable;
        enable = 1'b1;
        step(1);
        check("R2 out_en on", {3'b0, out_en}, 4'h1);
    endtask

    task automatic t_standby;
        standby_n = 1'b0;
        step(1);
        check("R3 out_en off", {3'b0, out_en}, 4'h0);
        check("R3 flags untouched", {1'b0, live}, 4'h0);
        standby_n = 1'b1;
        step(1);
        check("R3 release", {3'b0, out_en}, 4'h1);
    endtask

    task automatic t_ocp_mask;
        ocp = 1'b1;
        step(MASK - 1);
        check("R4 short burst live", {1'b0, live}, 4'h0);
        check("R4 short burst out_en", {3'b0, out_en}, 4'h1);
        ocp = 1'b0;
        step(1);
        ocp = 1'b1;
        step(MASK - 1);
        check("R4 restart after gap", {1'b0, live}, 4'h0);
        step(1);
        check("R4 accepted live", {1'b0, live}, 4'h1);
        check("R4 accepted out_en", {3'b0, out_en}, 4'h0);
        check("R4 accepted any", {3'b0, any}, 4'h1);
        ocp = 1'b0;
        step(5);
        check("R5 latched live", {1'b0, live}, 4'h1);
        check("R5 latched out_en", {3'b0, out_en}, 4'h0);
    endtask

    task automatic t_en_clear;
        enable = 1'b0;
        step(MINL - 1);
        check("R2 enable low", {3'b0, out_en}, 4'h0);
        enable = 1'b1;
        step(1);
        check("R6 short low keeps latch", {1'b0, live}, 4'h1);
        check("R6 short low out_en", {3'b0, out_en}, 4'h0);
        enable = 1'b0;
        step(MINL);
        enable = 1'b1;
        step(1);
        check("R6 qualified rise clears", {1'b0, live}, 4'h0);
        check("R6 qualified rise out_en", {3'b0, out_en}, 4'h1);
    endtask

    task automatic t_uv;
        ocp = 1'b1;
        step(MASK);
        ocp = 1'b0;
        check("R4 retrip", {1'b0, live}, 4'h1);
        uvm = 1'b1;
        step(1);
        check("R7 motor uv live", {1'b0, live}, 4'h4);
        check("R7 motor uv out_en", {3'b0, out_en}, 4'h0);
        uvm = 1'b0;
        step(1);
        check("R7 motor uv recover", {3'b0, out_en}, 4'h1);
        check("R7 ocp cleared by uv", {1'b0, live}, 4'h0);
        uvl = 1'b1;
        step(4);
        check("R7 logic uv live", {1'b0, live}, 4'h4);
        check("R7 logic uv out_en", {3'b0, out_en}, 4'h0);
        uvl = 1'b0;
        step(1);
        check("R7 logic uv recover", {3'b0, out_en}, 4'h1);
    endtask

    task automatic t_therm;
        cool = 1'b0;
        hot  = 1'b1;
        step(1);
        check("R8 trip live", {1'b0, live}, 4'h2);
        check("R8 trip out_en", {3'b0, out_en}, 4'h0);
        hot = 1'b0;
        step(4);
        check("R8 hold until cool", {1'b0, live}, 4'h2);
        check("R8 hold out_en", {3'b0, out_en}, 4'h0);
        cool = 1'b1;
        step(1);
        check("R8 recover live", {1'b0, live}, 4'h0);
        check("R8 recover out_en", {3'b0, out_en}, 4'h1);
    endtask

    task automatic t_sticky;
        check("R9 sticky all", {1'b0, seen}, 4'h7);
        check("R9 any clear", {3'b0, any}, 4'h0);
        rst = 1'b1;
        step(2);
        check("R1 reset sticky", {1'b0, seen}, 4'h0);
        check("R1 reset out_en", {3'b0, out_en}, 4'h0);
        rst = 1'b0;
        step(1);
        check("R9 sticky stays clear", {1'b0, seen}, 4'h0);
    endtask

    initial begin
        t_reset();
        t_enable();
        t_standby();
        t_ocp_mask();
        t_en_clear();
        t_uv();
        t_therm();
        t_sticky();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule